// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the slave side of a three-wire control port that loads a small bank of 8-bit configuration registers and reads them back. A host shifts a 14-bit frame on `sdi`, one bit per rising edge of `sck`. The frame is a 6-bit address followed by an 8-bit data word, both sent most significant bit first. A rising edge on the separate strobe `sen` then acts on the frame. If address bit 4 is clear, the frame writes the register at that address. If address bit 4 is set, the frame is a read-back request for the register at the same address with bit 4 cleared, and the data bits are ignored. Address 6'h04 is not a register: a write to it returns every register to its default value.

All three serial pins are brought into the `clk` domain through synchronizers, and their edges are found there. A frame state machine counts the bits and has four states. `FR_IDLE` means no bits have arrived yet. `FR_SHIFT` means fewer than 14 bits have arrived. `FR_FULL` means exactly 14 bits have arrived. `FR_OVER` means more than 14 bits have arrived. The machine has these transitions:
- Idle-to-shift on the first `sck` rise.
- Shift-to-full on the fourteenth rise.
- Full-to-over on any further rise.
- Any-to-idle on a `sen` rise, which commits the frame only from `FR_FULL`.

Read-back data goes out on `pin_out`, which is shared with the parallel output bit `par_bit` and is gated by the active-low enable `oe_n`.

Top module: `scp_ctrl_port`

## Requirements
- R1: After reset every implemented register (addresses 0 to 3 and 5 to 7) holds its default value {addr[3:0], ~addr[3:0]}. The byte for slot 4 in `cfg_out` reads 8'h00. With `oe_n` low and no read-back running, `pin_out` equals `par_bit`.
- R2: A frame of 14 bits, sampled on `sck` rising edges, carries address[5:0] then data[7:0], MSB first. With address bit 4 clear, it writes the data into the register at that address. Register k appears at `cfg_out[8k+7:8k]`.
- R3: A register keeps its old value while a frame is being shifted in. It changes only after the `sen` rising edge.
- R4: When `sen` rises after a number of `sck` rising edges other than 14, whether fewer or more, no register changes.
- R5: A write to address 6'h04, with any data value, returns every register to its default.
- R6: A write with address bit 4 clear to any address that is not an implemented register (8 and above, for example 6'h08, 6'h24 or 6'h2B) changes nothing.
- R7: A frame with address bit 4 set loads the register at the address with bit 4 cleared into the read-back shifter on the `sen` edge. `pin_out` then shows bit 7, and each later `sck` falling edge moves it to the next lower bit. A read changes no register.
- R8: While `oe_n` is high, `pin_out` is 0. After the eighth falling edge following a read-back load, `pin_out` returns to `par_bit`.
- R9: A new frame can be shifted in while the previous read-back word is still going out, and that frame commits normally.
- R10: A read frame for address 6'h14 returns 8'h00, because slot 4 is not implemented, and it does not perform a software reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset; loads the defaults |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on the rising edge of `sck` |
| sen | input | 1 | Commit strobe; acts on its rising edge |
| oe_n | input | 1 | Active-low output enable for the shared pin |
| par_bit | input | 1 | Parallel output bit that shares the pin |
| pin_out | output | 1 | Shared pin: read-back bit or `par_bit` |
| cfg_out | output | NUM_REGS*DATA_W | Register bank contents, register k at byte k |

## Verification
The bench targets frames of the wrong length on both sides of 14. A design that committed on any strobe would change a register after 13 or 15 bits. It also writes to addresses beyond the bank and to 6'h24, where a design that drops address bits would alias these onto real registers. Read-back is checked bit by bit while the next write frame is clocked in. An off-by-one shifter would show bit 6 first or hold the pin for a ninth bit. The bench reads address 6'h14 and then toggles `oe_n` during a read-back. A decoder that ignores bit 4 would reset the bank on that read, and a gate in the wrong place would leak data while the pin is disabled.

// File: rtl/scp_pkg.sv
package scp_pkg;

    // Frame progress as seen by the bit counter state machine.
    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SHIFT,
        FR_FULL,
        FR_OVER
    } frame_state_t;

    // Default register content: upper nibble is the index, lower nibble its complement.
    function automatic logic [31:0] reg_default(input int idx);
        logic [3:0] n;
        n = idx[3:0];
        return {8{n}} ^ 32'h0F0F_0F0F;
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
    parameter int NUM_REGS  = 8,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int SRST_ADDR = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] cfg_out
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g == SRST_ADDR) begin : g_hole
            assign cfg_out[g*DATA_W +: DATA_W] = '0;
        end else begin : g_reg
            localparam logic [31:0] DEF_W = scp_pkg::reg_default(g);
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= DEF_W[DATA_W-1:0];
                else if (soft_rst)
                    q <= DEF_W[DATA_W-1:0];
                else if (wr_en && wr_addr == ADDR_W'(g))
                    q <= wr_data;
            end
            assign cfg_out[g*DATA_W +: DATA_W] = q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = cfg_out[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/scp_rdout.sv
module scp_rdout #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              bit_out,
    output logic              active
);
    localparam int LEFT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh;
    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= load_data;
            left <= LEFT_W'(DATA_W);
        end else if (shift && left != '0) begin
            sh   <= {sh[DATA_W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign bit_out = sh[DATA_W-1];
    assign active  = (left != '0);
endmodule

// File: rtl/scp_ctrl_port.sv
module scp_ctrl_port #(
    parameter int NUM_REGS    = 8,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int RD_SEL_BIT  = 4,
    parameter int SRST_ADDR   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck,
    input  logic                       sdi,
    input  logic                       sen,
    input  logic                       oe_n,
    input  logic                       par_bit,
    output logic                       pin_out,
    output logic [NUM_REGS*DATA_W-1:0] cfg_out
);
    import scp_pkg::*;

    localparam int FRAME_LEN = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);

    // Pin synchronizers and edge detection
    logic sck_l, sdi_l, sen_l, sck_p, sen_p;
    logic sck_rise, sck_fall, sen_rise;

    scp_sync #(.STAGES(SYNC_STAGES)) u_sck (.clk(clk), .rst_n(rst_n), .din(sck), .lvl(sck_l));
    scp_sync #(.STAGES(SYNC_STAGES)) u_sdi (.clk(clk), .rst_n(rst_n), .din(sdi), .lvl(sdi_l));
    scp_sync #(.STAGES(SYNC_STAGES)) u_sen (.clk(clk), .rst_n(rst_n), .din(sen), .lvl(sen_l));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= 1'b0;
            sen_p <= 1'b0;
        end else begin
            sck_p <= sck_l;
            sen_p <= sen_l;
        end
    end

    assign sck_rise = sck_l & ~sck_p;
    assign sck_fall = ~sck_l & sck_p;
    assign sen_rise = sen_l & ~sen_p;

    // Frame shifter and saturating bit counter
    logic [FRAME_LEN-1:0] frame_sh;
    logic [CNT_W-1:0]     bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_sh <= '0;
            bit_cnt  <= '0;
        end else begin
            if (sck_rise) frame_sh <= {frame_sh[FRAME_LEN-2:0], sdi_l};
            if (sen_rise)
                bit_cnt <= '0;
            else if (sck_rise && bit_cnt != CNT_W'(FRAME_LEN + 1))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Frame state machine
    frame_state_t state, state_nx;
    logic         commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE:  if (sen_rise) state_nx = FR_IDLE;
                      else if (sck_rise) state_nx = FR_SHIFT;
            FR_SHIFT: if (sen_rise) state_nx = FR_IDLE;
                      else if (sck_rise && bit_cnt == CNT_W'(FRAME_LEN - 1)) state_nx = FR_FULL;
            FR_FULL:  if (sen_rise) state_nx = FR_IDLE;
                      else if (sck_rise) state_nx = FR_OVER;
            FR_OVER:  if (sen_rise) state_nx = FR_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            FR_FULL:                   commit = sen_rise;
            FR_IDLE, FR_SHIFT, FR_OVER: commit = 1'b0;
        endcase
    end

    // Frame decode
    logic [ADDR_W-1:0] addr, reg_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              is_read, soft_rst, wr_en, rd_load;

    assign addr     = frame_sh[FRAME_LEN-1 -: ADDR_W];
    assign wr_data  = frame_sh[DATA_W-1:0];
    assign is_read  = addr[RD_SEL_BIT];
    assign reg_addr = addr & ~(ADDR_W'(1) << RD_SEL_BIT);
    assign soft_rst = commit & ~is_read & (addr == ADDR_W'(SRST_ADDR));
    assign wr_en    = commit & ~is_read & (addr != ADDR_W'(SRST_ADDR))
                    & (32'(addr) < 32'(NUM_REGS));
    assign rd_load  = commit & is_read;

    scp_regfile #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRST_ADDR(SRST_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_addr(addr), .wr_data(wr_data), .rd_addr(reg_addr), .rd_data(rd_data),
        .cfg_out(cfg_out)
    );

    // Read-back shifter and shared pin
    logic rd_bit, rd_active;

    scp_rdout #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .load_data(rd_data),
        .shift(sck_fall), .bit_out(rd_bit), .active(rd_active)
    );

    assign pin_out = ~oe_n & (rd_active ? rd_bit : par_bit);
endmodule

// File: rtl/scp_ctrl_chk.sv
module scp_ctrl_chk #(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 8,
    parameter int FRAME_LEN = 14,
    parameter int CNT_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       commit,
    input logic [CNT_W-1:0]           bit_cnt,
    input logic [NUM_REGS*DATA_W-1:0] cfg_out,
    input logic                       rd_load,
    input logic [DATA_W-1:0]          rd_data,
    input logic                       rd_active,
    input logic                       rd_bit,
    input logic                       oe_n,
    input logic                       pin_out
);
    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_out) |-> $past(commit));

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> bit_cnt == CNT_W'(FRAME_LEN));

    // R7
    rd_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> rd_active && rd_bit == $past(rd_data[DATA_W-1]));

    // R8
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !pin_out);
endmodule

bind scp_ctrl_port scp_ctrl_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .bit_cnt(bit_cnt), .cfg_out(cfg_out),
    .rd_load(rd_load), .rd_data(rd_data), .rd_active(rd_active), .rd_bit(rd_bit),
    .oe_n(oe_n), .pin_out(pin_out)
);

// File: tb/scp_ctrl_port_test.sv
module scp_ctrl_port_test;
    localparam int NR = 8;
    localparam int DW = 8;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sdi = 1'b0, sen = 1'b0;
    logic oe_n = 1'b0, par_bit = 1'b1;
    logic pin_out;
    logic [NR*DW-1:0] cfg_out;

    always #10 clk = ~clk;

    scp_ctrl_port uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sen(sen),
        .oe_n(oe_n), .par_bit(par_bit), .pin_out(pin_out), .cfg_out(cfg_out)
    );

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] model [NR];

    // Scoreboard queues: kind 0 = register byte, kind 1 = shared pin
    int         q_kind [$];
    int         q_idx  [$];
    logic [7:0] q_exp  [$];
    string      q_req  [$];

    function automatic logic [7:0] dflt(input int i);
        logic [3:0] n;
        n = i[3:0];
        return (i == 4) ? 8'h00 : {n, ~n};
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input string req, input int kind, input int idx, input logic [7:0] e);
        q_kind.push_back(kind); q_idx.push_back(idx);
        q_exp.push_back(e);     q_req.push_back(req);
    endtask

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (q_kind.size() > 0) begin
                int k, ix; logic [7:0] e, a; string r;
                k = q_kind.pop_front(); ix = q_idx.pop_front();
                e = q_exp.pop_front();  r = q_req.pop_front();
                a = (k == 0) ? cfg_out[ix*DW +: DW] : {7'b0, pin_out};
                n_run++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: %s %0d actual=%h expected=%h",
                             r, (k == 0) ? "reg" : "pin", ix, a, e);
                end
            end
        end
    end

    task automatic expect_reg(input string req, input int idx);
        push_exp(req, 0, idx, model[idx]);
        wait_clks(2);
    endtask

    task automatic expect_all(input string req);
        for (int i = 0; i < NR; i++) push_exp(req, 0, i, model[i]);
        wait_clks(2);
    endtask

    task automatic expect_pin(input string req, input logic b);
        push_exp(req, 1, 0, {7'b0, b});
        wait_clks(2);
    endtask

    task automatic sck_pulse(input logic b);
        sdi = b; wait_clks(6);
        sck = 1'b1; wait_clks(6);
        sck = 1'b0; wait_clks(6);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sck_pulse(v[i]);
    endtask

    task automatic strobe();
        sen = 1'b1; wait_clks(6);
        sen = 1'b0; wait_clks(8);
    endtask

    task automatic send_frame(input logic [5:0] a, input logic [7:0] d);
        send_bits({18'b0, a, d}, 14);
        strobe();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [13:0] nxt;
        for (int i = 0; i < NR; i++) model[i] = dflt(i);
        wait_clks(5); rst_n = 1'b1; wait_clks(6);

        // R1 reset state and pin
        expect_all("R1");
        expect_pin("R1", 1'b1);
        oe_n = 1'b1; wait_clks(6); expect_pin("R8", 1'b0);
        oe_n = 1'b0; wait_clks(6);

        // R2 / R3 writes
        send_bits({18'b0, 6'h02, 8'h3C}, 14);
        expect_reg("R3", 2);
        strobe(); model[2] = 8'h3C; expect_reg("R2", 2);
        send_frame(6'h07, 8'h81); model[7] = 8'h81; expect_reg("R2", 7);
        send_frame(6'h00, 8'hFF); model[0] = 8'hFF; expect_reg("R2", 0);

        // R4 short and long frames
        send_bits({18'b0, 6'h03, 8'h11}, 13); strobe(); expect_all("R4");
        send_bits({17'b0, 1'b0, 6'h03, 8'h11}, 15); strobe(); expect_all("R4");

        // R6 unimplemented write addresses
        send_frame(6'h08, 8'hEE);
        send_frame(6'h24, 8'hEE);
        send_frame(6'h2B, 8'hEE);
        expect_all("R6");

        // R7 read-back of register 2 overlapped with a write (R9)
        send_frame(6'h12, 8'h00);
        expect_pin("R7", model[2][7]);
        nxt = {6'h05, 8'hC3};
        for (int k = 1; k <= 14; k++) begin
            sck_pulse(nxt[14-k]);
            if (k <= 7)      expect_pin("R7", model[2][7-k]);
            else if (k == 8) expect_pin("R8", 1'b1);
        end
        strobe(); model[5] = 8'hC3;
        expect_reg("R9", 5);
        expect_all("R7");

        // R10 read of the soft-reset slot
        send_frame(6'h14, 8'hFF);
        expect_pin("R10", 1'b0);
        expect_all("R10");
        for (int k = 0; k < 8; k++) sck_pulse(1'b0);
        expect_pin("R8", 1'b1);
        strobe(); expect_all("R4");

        // R8 enable gating during a read-back of register 7 (0x81)
        send_frame(6'h17, 8'h00);
        expect_pin("R7", 1'b1);
        oe_n = 1'b1; wait_clks(6); expect_pin("R8", 1'b0);
        oe_n = 1'b0; wait_clks(6); expect_pin("R8", 1'b1);
        sck_pulse(1'b0); expect_pin("R7", 1'b0);
        for (int k = 0; k < 6; k++) sck_pulse(1'b0);
        expect_pin("R7", 1'b1);
        sck_pulse(1'b0); expect_pin("R8", 1'b1);
        strobe();

        // R5 software reset
        send_frame(6'h04, 8'hA7);
        for (int i = 0; i < NR; i++) model[i] = dflt(i);
        expect_all("R5");

        wait_clks(4);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule